// File: doc/BRIEF.md
# Multiplexed Gated Frequency Counter

This block measures how often a digital input toggles. A time-base counter opens a sample gate of fixed length (100 ms at the default clock). The rising edges seen while the gate is open are counted in a chain of decimal (BCD) decades. When the gate closes, the count is copied into a result register and the chain is cleared. The display therefore holds steady while the next gate runs. An active-low flag is low for exactly the length of the gate, and a short hold interval separates successive gates.

The result drives a common-cathode seven-segment display through one shared set of segment lines and one cathode line per digit. Each slot of the scan starts with a blanking interval in which all segments and all cathodes are off. The segment pattern for the slot's digit is then applied. Only after a set-up interval is that digit's cathode pulled low. Every position is refreshed at 500 Hz. Position 0 is the resolution digit and is never driven. The lowest counted decade appears at position 1. The decimal point is lit together with position 4.

Top module: `gated_freq_meter`

## Requirements
- R1: While `rst` is high, `meas_n` is high, `seg` and `dp` are 0 and every `dig_n` bit is high; after reset every shown position reads 0 until the first gate has closed.
- R2: Starting with the first clock edge after `rst` falls, `meas_n` is low for exactly GATE_CYCLES consecutive cycles (CLK_HZ/1000*GATE_MS), then high for exactly HOLD_CYCLES cycles, and this repeats.
- R3: Each rising edge of `cnt_in` that arrives while `meas_n` is low (inputs pass through a 2-flop synchroniser) is counted once. The total is shown from 3 cycles after `meas_n` rises, at the latest one scan frame later. It stays shown through the next gate.
- R4: Rising edges of `cnt_in` that arrive while `meas_n` is high are not counted in any result.
- R5: Position p (1 to NUM_POS-1) shows decade p-1 of the count (position 1 is the units). Leading zeros are shown as 0, and carries propagate across decades (for example 99 followed by one more edge shows 100).
- R6: `seg` bit 0 is segment a through bit 6 segment g. The digits 0 to 9 use the codes 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R7: At most one `dig_n` bit is low at a time. Each position is pulsed low once every NUM_POS*SLOT_CYCLES cycles (500 Hz per digit), for SLOT_CYCLES-BLANK_CYCLES-SETUP_CYCLES consecutive cycles.
- R8: Between two lit digits there are at least BLANK_CYCLES cycles with `seg`=0, `dp`=0 and all `dig_n` high.
- R9: The segment pattern and `dp` of a digit are applied exactly SETUP_CYCLES cycles before its `dig_n` bit goes low, and stay unchanged while it is low.
- R10: `dp` is high whenever `dig_n[DP_POS]` (default 4) is low, and low whenever any other digit is low.
- R11: `dig_n[0]`, the resolution position, is never pulled low.
- R12: A reset asserted in the middle of a gate clears the count and the shown result, and a fresh full gate starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 1 | Signal whose rising edges are counted (asynchronous) |
| meas_n | output | 1 | Low while the sample gate is open |
| dig_n | output | NUM_POS | Per-position cathode select, active low |
| seg | output | 7 | Segment anodes a..g, active high |
| dp | output | 1 | Decimal point anode, active high |

## Verification
The result register can be updated at the end of a gate while the scanner is in the middle of a lit digit. The gate period is not a multiple of the scan frame, so successive measurements move the latch point across every phase of the scan. Each lit run is watched cycle by cycle: the pattern on `seg` and `dp` must not change while a cathode is low, and a new value may only appear after the next blanking interval. After each measurement, two whole frames are decoded and compared digit by digit with the count the bench drove.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;

  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg7_t;   // bit 0 = a ... bit 6 = g

  function automatic seg7_t bcd_to_seg(input bcd_t d);
    seg7_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fcnt_timebase.sv
// Sample-gate generator: a free-running period counter split into a gate
// phase and a hold phase; issues a one-cycle latch request in the first
// hold cycle, after the last counted edge has settled into the chain.
module fcnt_timebase #(
  parameter int unsigned GATE_CYCLES = 5_000_000,
  parameter int unsigned HOLD_CYCLES = 50_000
) (
  input  logic clk,
  input  logic rst,
  output logic meas_n_o,
  output logic latch_o
);
  localparam int unsigned PERIOD = GATE_CYCLES + HOLD_CYCLES;
  localparam int unsigned TW     = $clog2(PERIOD);
  localparam logic [TW-1:0] T_LAST  = TW'(PERIOD - 1);
  localparam logic [TW-1:0] T_GEND  = TW'(GATE_CYCLES - 1);
  localparam logic [TW-1:0] T_LATCH = TW'(GATE_CYCLES);

  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] tcnt_nx;
  logic          meas_n_q;

  always_comb begin
    tcnt_nx = (tcnt_q == T_LAST) ? '0 : tcnt_q + 1'b1;
  end

  // reset parks the counter on the last hold cycle so that the first
  // edge after release opens a full gate
  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q   <= T_LAST;
      meas_n_q <= 1'b1;
    end else begin
      tcnt_q   <= tcnt_nx;
      meas_n_q <= !(tcnt_nx <= T_GEND);
    end
  end

  assign meas_n_o = meas_n_q;
  assign latch_o  = meas_n_q && (tcnt_q == T_LATCH);

endmodule

// File: rtl/fcnt_edge_sync.sv
// Brings the asynchronous count input into the clock domain and
// produces a single-cycle pulse per rising edge.
module fcnt_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned DW = SYNC_STAGES + 1;

  logic [DW-1:0] shf_q;

  always_ff @(posedge clk) begin
    if (rst) shf_q <= '0;
    else     shf_q <= {shf_q[DW-2:0], async_i};
  end

  assign rise_o = shf_q[DW-2] & ~shf_q[DW-1];

endmodule

// File: rtl/fcnt_bcd_chain.sv
// Cascade of decimal decades plus the result register shown on the
// display. A latch request copies the running count and clears it.
module fcnt_bcd_chain #(
  parameter int unsigned NUM_DEC = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inc_i,
  input  logic                 latch_i,
  output logic [NUM_DEC*4-1:0] res_o
);
  logic [NUM_DEC-1:0]   cy;
  logic [NUM_DEC*4-1:0] run_w;
  logic [NUM_DEC*4-1:0] res_q;

  assign cy[0] = inc_i;

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    logic [3:0] d_q;

    always_ff @(posedge clk) begin
      if (rst || latch_i)  d_q <= '0;
      else if (cy[i])      d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
    end

    assign run_w[i*4 +: 4] = d_q;

    if (i < NUM_DEC - 1) begin : g_cy
      assign cy[i+1] = cy[i] & (d_q == 4'd9);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          res_q <= '0;
    else if (latch_i) res_q <= run_w;
  end

  assign res_o = res_q;

endmodule

// File: rtl/fcnt_scan.sv
// Display multiplexer: per slot a blank phase, a segment set-up phase and
// a lit phase with one cathode pulled low. The pattern is captured once
// per slot, so a result update never alters a digit that is lit.
module fcnt_scan
  import fcnt_pkg::*;
#(
  parameter int unsigned NUM_POS      = 8,
  parameter int unsigned SLOT_CYCLES  = 12_500,
  parameter int unsigned BLANK_CYCLES = 250,
  parameter int unsigned SETUP_CYCLES = 125,
  parameter int unsigned DP_POS       = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [(NUM_POS-1)*4-1:0] res_i,
  output logic [NUM_POS-1:0]       dig_n_o,
  output seg7_t                    seg_o,
  output logic                     dp_o
);
  localparam int unsigned SW = $clog2(SLOT_CYCLES);
  localparam int unsigned PW = (NUM_POS > 1) ? $clog2(NUM_POS) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SLOT_CYCLES - 1);
  localparam logic [SW-1:0] S_LOAD = SW'(BLANK_CYCLES);
  localparam logic [SW-1:0] S_FIRE = SW'(BLANK_CYCLES + SETUP_CYCLES);
  localparam logic [PW-1:0] P_LAST = PW'(NUM_POS - 1);
  localparam logic [PW-1:0] P_DP   = PW'(DP_POS);
  localparam logic [NUM_POS-1:0] ONE = NUM_POS'(1);

  logic [SW-1:0]      slot_q;
  logic [PW-1:0]      pos_q;
  bcd_t               cur_d;
  logic [NUM_POS-1:0] dig_n_q;
  seg7_t              seg_q;
  logic               dp_q;

  // decade for the current position; position 0 has none
  always_comb begin
    cur_d = '0;
    for (int k = 1; k < NUM_POS; k++) begin
      if (pos_q == PW'(k)) cur_d = res_i[(k-1)*4 +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      pos_q   <= '0;
      dig_n_q <= '1;
      seg_q   <= '0;
      dp_q    <= 1'b0;
    end else begin
      slot_q <= (slot_q == S_LAST) ? '0 : slot_q + 1'b1;
      if (slot_q == S_LAST) pos_q <= (pos_q == P_LAST) ? '0 : pos_q + 1'b1;

      if (slot_q < S_LOAD) begin
        seg_q   <= '0;
        dp_q    <= 1'b0;
        dig_n_q <= '1;
      end else if (slot_q == S_LOAD) begin
        seg_q   <= (pos_q != '0) ? bcd_to_seg(cur_d) : '0;
        dp_q    <= (pos_q == P_DP);
        dig_n_q <= '1;
      end else if (slot_q >= S_FIRE && pos_q != '0) begin
        dig_n_q <= ~(ONE << pos_q);
      end
    end
  end

  assign dig_n_o = dig_n_q;
  assign seg_o   = seg_q;
  assign dp_o    = dp_q;

endmodule

// File: rtl/gated_freq_meter.sv
module gated_freq_meter
  import fcnt_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned GATE_MS      = 100,
  parameter int unsigned HOLD_CYCLES  = 50_000,
  parameter int unsigned REFRESH_HZ   = 500,
  parameter int unsigned NUM_POS      = 8,
  parameter int unsigned BLANK_CYCLES = 250,
  parameter int unsigned SETUP_CYCLES = 125,
  parameter int unsigned DP_POS       = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_in,
  output logic               meas_n,
  output logic [NUM_POS-1:0] dig_n,
  output logic [6:0]         seg,
  output logic               dp
);
  localparam int unsigned GATE_CYCLES = CLK_HZ / 1000 * GATE_MS;
  localparam int unsigned SLOT_CYCLES = CLK_HZ / (REFRESH_HZ * NUM_POS);
  localparam int unsigned NUM_DEC     = NUM_POS - 1;

  logic                 latch;
  logic                 rise;
  logic [NUM_DEC*4-1:0] res;

  fcnt_timebase #(
    .GATE_CYCLES(GATE_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) tb_i (
    .clk(clk), .rst(rst), .meas_n_o(meas_n), .latch_o(latch)
  );

  fcnt_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk(clk), .rst(rst), .async_i(cnt_in), .rise_o(rise)
  );

  fcnt_bcd_chain #(
    .NUM_DEC(NUM_DEC)
  ) chain_i (
    .clk(clk), .rst(rst), .inc_i(rise & ~meas_n), .latch_i(latch), .res_o(res)
  );

  fcnt_scan #(
    .NUM_POS(NUM_POS),
    .SLOT_CYCLES(SLOT_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES),
    .SETUP_CYCLES(SETUP_CYCLES),
    .DP_POS(DP_POS)
  ) scan_i (
    .clk(clk), .rst(rst), .res_i(res), .dig_n_o(dig_n), .seg_o(seg), .dp_o(dp)
  );

endmodule

// File: rtl/fcnt_chk.sv
module fcnt_chk #(
  parameter int unsigned GATE_CYCLES = 5_000_000,
  parameter int unsigned NUM_POS     = 8,
  parameter int unsigned DP_POS      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               meas_n,
  input logic [NUM_POS-1:0] dig_n,
  input logic [6:0]         seg,
  input logic               dp
);
  localparam int unsigned CW = $clog2(GATE_CYCLES + 2) + 1;

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || meas_n) low_cnt <= '0;
    else               low_cnt <= low_cnt + 1'b1;
  end

  p_gate_max_r2: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= CW'(GATE_CYCLES))
    else $error("gate longer than allowed");

  p_gate_len_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(meas_n) |-> (low_cnt == CW'(GATE_CYCLES)))
    else $error("gate closed early");

  p_one_digit_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_n))
    else $error("more than one cathode low");

  p_blank_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(&dig_n) |-> (seg == 7'd0 && !dp))
    else $error("no blanking after lit digit");

  p_seg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(&dig_n) |-> ($stable(seg) && $stable(dp)))
    else $error("segments changed around a lit digit");

  p_dp_on_r10: assert property (@(posedge clk) disable iff (rst)
    !dig_n[DP_POS] |-> dp)
    else $error("decimal point missing");

  p_dp_off_r10: assert property (@(posedge clk) disable iff (rst)
    (dig_n[DP_POS] && !(&dig_n)) |-> !dp)
    else $error("decimal point on wrong digit");

  p_res_pos_r11: assert property (@(posedge clk) disable iff (rst)
    dig_n[0])
    else $error("resolution position driven");

endmodule

bind gated_freq_meter fcnt_chk #(
  .GATE_CYCLES(GATE_CYCLES),
  .NUM_POS(NUM_POS),
  .DP_POS(DP_POS)
) chk_i (
  .clk(clk), .rst(rst), .meas_n(meas_n), .dig_n(dig_n), .seg(seg), .dp(dp)
);

// File: tb/gated_freq_meter_tb_top.sv
`timescale 1ns/1ps
module gated_freq_meter_tb_top;
  localparam int CLK_HZ = 80_000;
  localparam int GATE_MS = 12;
  localparam int GATE = CLK_HZ / 1000 * GATE_MS;   // 960
  localparam int HOLD = 37;
  localparam int NPOS = 8;
  localparam int SLOT = CLK_HZ / (500 * NPOS);      // 20
  localparam int BLANK = 3;
  localparam int SETUP = 2;
  localparam int DPP = 4;
  localparam int FRAME = NPOS * SLOT;
  localparam int LIT = SLOT - BLANK - SETUP;
  localparam int WD_LIMIT = 150_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_in = 1'b0;
  logic meas_n;
  logic [NPOS-1:0] dig_n;
  logic [6:0] seg;
  logic dp;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gated_freq_meter #(
    .CLK_HZ(CLK_HZ), .GATE_MS(GATE_MS), .HOLD_CYCLES(HOLD), .REFRESH_HZ(500),
    .NUM_POS(NPOS), .BLANK_CYCLES(BLANK), .SETUP_CYCLES(SETUP), .DP_POS(DPP),
    .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .meas_n(meas_n),
    .dig_n(dig_n), .seg(seg), .dp(dp)
  );

  function automatic void chk(bit ok, string req, int act, int exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function automatic logic [6:0] seg_of(int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic int p10(int e);
    int v = 1;
    for (int i = 0; i < e; i++) v = v * 10;
    return v;
  endfunction

  // ---------------- continuous monitor of gate and scan timing -------------
  int cyc = 0;
  bit prev_meas = 1'b1;
  bit seen_rise = 1'b0;
  int low_run = 0, high_run = 0;
  int blank_run = 0, setup_run = 0, last_blank = 0, lit_run = 0;
  logic [NPOS-1:0] prev_dig = '1;
  logic [6:0] prev_seg = '0;
  logic prev_dp = 1'b0;
  int last_fall1 = -1;
  int n_lit = 0, n_refresh = 0, n_gate = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_meas = 1'b1; seen_rise = 1'b0; low_run = 0; high_run = 0;
      blank_run = 0; setup_run = 0; last_blank = 0; lit_run = 0;
      prev_dig = '1; prev_seg = '0; prev_dp = 1'b0; last_fall1 = -1;
    end else begin
      // R2: gate and hold lengths
      if (meas_n && !prev_meas) begin
        n_gate++;
        chk(low_run == GATE, "R2", low_run, GATE, "gate length");
        seen_rise = 1'b1;
        low_run = 0; high_run = 0;
      end else if (!meas_n && prev_meas) begin
        if (seen_rise) chk(high_run == HOLD, "R2", high_run, HOLD, "hold length");
        low_run = 0; high_run = 0;
      end
      if (meas_n) high_run++; else low_run++;
      prev_meas = meas_n;

      if (&dig_n) begin
        if (!(&prev_dig))
          chk(lit_run == LIT, "R7", lit_run, LIT, "lit duration");
        lit_run = 0;
        if (seg == 7'd0 && !dp) begin
          blank_run++; setup_run = 0;
        end else begin
          if (setup_run == 0) last_blank = blank_run;
          setup_run++; blank_run = 0;
        end
      end else begin
        if (!dig_n[0]) chk(1'b0, "R11", 0, 1, "resolution position pulsed");
        if ($countones(~dig_n) != 1)
          chk(1'b0, "R7", $countones(~dig_n), 1, "cathodes low at once");
        chk(dp == !dig_n[DPP], "R10", dp, !dig_n[DPP], "decimal point");
        if (&prev_dig) begin
          n_lit++;
          chk(setup_run == SETUP, "R9", setup_run, SETUP, "segment set-up");
          chk(last_blank >= BLANK, "R8", last_blank, BLANK, "blank before digit");
          if (!dig_n[1]) begin
            if (last_fall1 >= 0) begin
              n_refresh++;
              chk(cyc - last_fall1 == FRAME, "R7", cyc - last_fall1, FRAME, "refresh period");
            end
            last_fall1 = cyc;
          end
          lit_run = 1;
        end else begin
          if (dig_n != prev_dig) chk(1'b0, "R8", 0, 1, "digit switch without blank");
          if (seg != prev_seg || dp != prev_dp)
            chk(1'b0, "R9", seg, prev_seg, "pattern changed while lit");
          lit_run++;
        end
        setup_run = 0; blank_run = 0;
      end
      prev_dig = dig_n; prev_seg = seg; prev_dp = dp;
    end
  end

  // ---------------- stimulus and result reading ---------------------------
  logic [6:0] got_pat [NPOS];
  bit got_seen [NPOS];

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cnt_in = 1'b1;
      @(negedge clk);
      @(negedge clk) cnt_in = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic read_frame();
    for (int k = 0; k < NPOS; k++) begin got_pat[k] = '0; got_seen[k] = 1'b0; end
    repeat (2 * FRAME) begin
      @(negedge clk);
      for (int k = 0; k < NPOS; k++)
        if (!dig_n[k]) begin got_pat[k] = seg; got_seen[k] = 1'b1; end
    end
  endtask

  task automatic check_display(int n, string req);
    chk(!got_seen[0], "R11", got_seen[0], 0, "position 0 seen lit");
    for (int p = 1; p < NPOS; p++) begin
      int d = (n / p10(p - 1)) % 10;
      chk(got_seen[p], req, got_seen[p], 1, $sformatf("position %0d lit", p));
      chk(got_pat[p] == seg_of(d), req, got_pat[p], seg_of(d),
          $sformatf("count %0d position %0d", n, p));
    end
  endtask

  // one measurement: optional edges in the preceding hold (R4), n edges in gate
  task automatic measure(int n, bit hold_noise, string req);
    @(posedge meas_n);
    if (hold_noise) begin
      repeat (6) @(negedge clk);
      pulses(5);
    end
    @(negedge meas_n);
    repeat (8) @(negedge clk);
    pulses(n);
    @(posedge meas_n);
    repeat (3) @(negedge clk);
    read_frame();
    check_display(n, req);
  endtask

  task automatic run_all();
    int dir_n [7] = '{0, 9, 10, 99, 100, 199, 230};
    // R1 reset state
    repeat (5) @(negedge clk);
    chk(meas_n == 1'b1, "R1", meas_n, 1, "meas_n in reset");
    chk(dig_n == '1, "R1", dig_n, 8'hFF, "cathodes in reset");
    chk(seg == 7'd0 && !dp, "R1", seg, 0, "segments in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(meas_n == 1'b0, "R2", meas_n, 0, "gate opens after reset");
    read_frame();
    check_display(0, "R1");

    // directed counts: decade carries and leading zeros (R5, R6)
    foreach (dir_n[i]) measure(dir_n[i], 1'b0, (i % 2) ? "R5" : "R3");

    // edges in the hold interval are ignored (R4)
    measure(17, 1'b1, "R4");
    measure(0, 1'b1, "R4");

    // random counts (R3, R6)
    for (int i = 0; i < 5; i++) measure($urandom_range(230, 0), (i == 2), "R6");

    // R12: reset in the middle of a gate
    @(negedge meas_n);
    repeat (8) @(negedge clk);
    pulses(30);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(meas_n == 1'b1, "R12", meas_n, 1, "meas_n during mid reset");
    rst = 1'b0;
    @(negedge clk);
    chk(meas_n == 1'b0, "R12", meas_n, 0, "new gate after mid reset");
    read_frame();
    check_display(0, "R12");
    pulses(12);
    @(posedge meas_n);
    repeat (3) @(negedge clk);
    read_frame();
    check_display(12, "R12");
  endtask

  initial begin
    int wd = 0;
    void'($urandom(32'd4711));
    fork
      begin run_all(); done = 1'b1; end
      begin
        while (!done && wd < WD_LIMIT) begin @(posedge clk); wd++; end
      end
    join_any
    if (!done) chk(1'b0, "R2", wd, WD_LIMIT, "watchdog expired");
    chk(n_gate > 0, "R2", n_gate, 1, "gates observed");
    chk(n_lit > 0, "R7", n_lit, 1, "lit digits observed");
    chk(n_refresh > 0, "R7", n_refresh, 1, "refresh periods observed");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule